// File: doc/BRIEF.md
# Request Id Allocator and Completion Tracker

This block hands out request ids from a fixed pool and ties each returned completion back to the context tag the requester stored with that id. An allocation returns the lowest-numbered id that is free and records a context tag against it. An allocation made while every id is taken is answered with a failure flag. A requester whose later setup step fails gives its id back through the release port.

Completions are 64-bit words in a circular ring held outside the block. The block reads ring entries at its own read pointer. A dequeue run walks forward from that pointer toward a write pointer supplied by the producer. The run stops at that pointer or when its budget is used up. The budget is first reduced to the number of requests still pending. For each word the block decodes the request id and an error code from parameterised bit fields. It then presents the stored context and frees the id. A word whose id holds no context is flagged as a hardware error.

Only one operation starts per cycle. While a dequeue run is active, allocation and release requests wait, and requesters hold their request lines until answered.

Top module: `rid_tracker`

## Requirements
- R1: An accepted allocation answers one cycle later with `alloc_done` high, `alloc_fail` low and `alloc_id` equal to the lowest id not in use. That id becomes used and stores `alloc_ctx`, and `pending` rises by one.
- R2: An accepted allocation when all NUM_IDS ids are in use answers with `alloc_done` and `alloc_fail` high. No id or count changes.
- R3: An accepted release answers one cycle later with `rel_done`. If `rel_id` was in use, that id is freed, its context is cleared and `pending` drops by one. If `rel_id` was already free, the release has no effect on the pool or `pending`.
- R4: Each completion consumed at ring entry `ring_rd_addr` is reported one cycle later on `cpl_valid`. `cpl_id` comes from word bits [ID_LSB +: ID_W] (bits [3:0] by default) and `cpl_err` from bits [ERR_LSB +: ERR_W] (bits [51:48] by default). `cpl_ctx` is the stored context. The id is then free and its context cleared.
- R5: A completion whose id has a stored context of zero (never allocated, or out of range) raises `cpl_hw_err`, and `pending` is not decremented.
- R6: A dequeue run consumes at most min(`deq_budget`, `pending`), both sampled when the run starts.
- R7: A run stops when the read pointer equals `hw_wr_ptr` or when its budget is exhausted. It then pulses `deq_done` with `deq_count` equal to the number of completions consumed.
- R8: The read pointer `ring_rd_addr` advances by one per completion and wraps from RING_DEPTH-1 to 0.
- R9: `busy` is high while a run is active. While `busy` is high, allocation, release and new dequeue requests are not accepted. In idle the order of precedence is dequeue, then release, then allocation.
- R10: After reset no id is in use, `pending` and `ring_rd_addr` are zero and every response output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Allocation request, held until `alloc_done` |
| alloc_ctx | input | CTX_W | Context tag to store for the new id |
| alloc_done | output | 1 | Allocation answered |
| alloc_fail | output | 1 | Pool exhausted |
| alloc_id | output | ID_W | Allocated id |
| rel_req | input | 1 | Release request, held until `rel_done` |
| rel_id | input | ID_W | Id to give back |
| rel_done | output | 1 | Release answered |
| deq_start | input | 1 | Start a dequeue run |
| deq_budget | input | BUD_W | Maximum completions for this run |
| hw_wr_ptr | input | PTR_W | Producer write pointer into the completion ring |
| ring_rd_addr | output | PTR_W | Read pointer, the ring entry being read |
| ring_rd_data | input | 64 | Ring word at `ring_rd_addr`, same cycle |
| busy | output | 1 | Dequeue run active |
| cpl_valid | output | 1 | Completion reported |
| cpl_id | output | ID_W | Decoded request id |
| cpl_ctx | output | CTX_W | Context stored for that id |
| cpl_err | output | ERR_W | Decoded error code |
| cpl_hw_err | output | 1 | Completion id had no context |
| deq_done | output | 1 | Run finished |
| deq_count | output | BUD_W | Completions consumed in the run |
| pending | output | CNT_W | Ids currently in use |

## Verification
The hardest case to reach is a run cut short by the pending clamp while the ring still holds unread words. The bench resets to an empty pool, allocates two ids, writes four ring words and asks for a large budget. Only two completions must come out. It then allocates one id and leaves a word naming a never-allocated id at the read pointer, to expose the hardware-error flag. Wrap-around and the hold-off of allocation are covered together: a five-entry run crosses the end of the ring while an allocation request is held high for its whole length.

// File: rtl/rid_pkg.sv
package rid_pkg;

    localparam int DESC_W = 64;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_DEQ   = 2'd1,
        OP_REL   = 2'd2,
        OP_ALLOC = 2'd3
    } op_e;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;

    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/rid_fields.sv
module rid_fields #(
    parameter int ID_LSB  = 0,
    parameter int ID_W    = 4,
    parameter int ERR_LSB = 48,
    parameter int ERR_W   = 4
) (
    input  logic [rid_pkg::DESC_W-1:0] word,
    output logic [ID_W-1:0]            id,
    output logic [ERR_W-1:0]           err
);
    assign id  = word[ID_LSB +: ID_W];
    assign err = word[ERR_LSB +: ERR_W];
endmodule

// File: rtl/rid_pool.sv
module rid_pool #(
    parameter int NUM_IDS = 16,
    parameter int CTX_W   = 16,
    parameter int ID_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_en,
    input  logic [CTX_W-1:0] take_ctx,
    input  logic             give_en,
    input  logic [ID_W-1:0]  give_id,
    input  logic             cpl_en,
    input  logic [ID_W-1:0]  cpl_id,
    output logic             any_free,
    output logic [ID_W-1:0]  low_id,
    output logic             give_used,
    output logic             cpl_used,
    output logic [CTX_W-1:0] cpl_ctx
);
    localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_IDS);

    logic [NUM_IDS-1:0] used_q;
    logic [CTX_W-1:0]   ctx_q [NUM_IDS];
    logic               give_ok, cpl_ok;

    // lowest free index: scan from the top so the lowest wins
    always_comb begin
        low_id = '0;
        for (int i = NUM_IDS - 1; i >= 0; i--) begin
            if (!used_q[i]) low_id = ID_W'(i);
        end
    end

    assign any_free  = ~&used_q;
    assign give_ok   = {1'b0, give_id} < LIMIT;
    assign cpl_ok    = {1'b0, cpl_id} < LIMIT;
    assign give_used = give_ok && used_q[give_id];
    assign cpl_used  = cpl_ok && used_q[cpl_id];
    assign cpl_ctx   = cpl_ok ? ctx_q[cpl_id] : '0;

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                used_q[g] <= 1'b0;
                ctx_q[g]  <= '0;
            end else if (take_en && low_id == ID_W'(g)) begin
                used_q[g] <= 1'b1;
                ctx_q[g]  <= take_ctx;
            end else if ((give_en && give_id == ID_W'(g)) ||
                         (cpl_en && cpl_id == ID_W'(g))) begin
                used_q[g] <= 1'b0;
                ctx_q[g]  <= '0;
            end
        end
    end
endmodule

// File: rtl/rid_walker.sv
module rid_walker #(
    parameter int RING_DEPTH = 8,
    parameter int PTR_W      = 3,
    parameter int BUD_W      = 8,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BUD_W-1:0] budget,
    input  logic [CNT_W-1:0] pending,
    input  logic [PTR_W-1:0] hw_wr_ptr,
    output logic             busy,
    output logic             take,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             done,
    output logic [BUD_W-1:0] done_count
);
    import rid_pkg::*;

    localparam logic [PTR_W-1:0] LAST = PTR_W'(RING_DEPTH - 1);

    walk_state_e      state_q;
    logic [BUD_W-1:0] remain_q, count_q;

    assign busy = (state_q == WALK_RUN);
    assign take = busy && (rd_ptr != hw_wr_ptr) && (remain_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= WALK_IDLE;
            remain_q   <= '0;
            count_q    <= '0;
            rd_ptr     <= '0;
            done       <= 1'b0;
            done_count <= '0;
        end else begin
            done <= 1'b0;
            if (state_q == WALK_IDLE) begin
                if (start) begin
                    state_q  <= WALK_RUN;
                    remain_q <= BUD_W'(umin(int'(budget), int'(pending)));
                    count_q  <= '0;
                end
            end else if (take) begin
                rd_ptr   <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
                remain_q <= remain_q - 1'b1;
                count_q  <= count_q + 1'b1;
            end else begin
                state_q    <= WALK_IDLE;
                done       <= 1'b1;
                done_count <= count_q;
            end
        end
    end
endmodule

// File: rtl/rid_tracker.sv
module rid_tracker #(
    parameter int NUM_IDS    = 16,
    parameter int CTX_W      = 16,
    parameter int RING_DEPTH = 8,
    parameter int BUD_W      = 8,
    parameter int ID_LSB     = 0,
    parameter int ERR_LSB    = 48,
    parameter int ERR_W      = 4,
    localparam int ID_W      = $clog2(NUM_IDS),
    localparam int PTR_W     = $clog2(RING_DEPTH),
    localparam int CNT_W     = $clog2(NUM_IDS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_req,
    input  logic [CTX_W-1:0] alloc_ctx,
    output logic             alloc_done,
    output logic             alloc_fail,
    output logic [ID_W-1:0]  alloc_id,
    input  logic             rel_req,
    input  logic [ID_W-1:0]  rel_id,
    output logic             rel_done,
    input  logic             deq_start,
    input  logic [BUD_W-1:0] deq_budget,
    input  logic [PTR_W-1:0] hw_wr_ptr,
    output logic [PTR_W-1:0] ring_rd_addr,
    input  logic [63:0]      ring_rd_data,
    output logic             busy,
    output logic             cpl_valid,
    output logic [ID_W-1:0]  cpl_id,
    output logic [CTX_W-1:0] cpl_ctx,
    output logic [ERR_W-1:0] cpl_err,
    output logic             cpl_hw_err,
    output logic             deq_done,
    output logic [BUD_W-1:0] deq_count,
    output logic [CNT_W-1:0] pending
);
    import rid_pkg::*;

    op_e              op;
    logic             take_en, give_used, cpl_used, any_free, walk_take;
    logic [ID_W-1:0]  low_id, word_id;
    logic [ERR_W-1:0] word_err;
    logic [CTX_W-1:0] pool_ctx;

    // one operation per cycle, only while no run is active
    always_comb begin
        op = OP_NONE;
        if (!busy) begin
            if (deq_start)      op = OP_DEQ;
            else if (rel_req)   op = OP_REL;
            else if (alloc_req) op = OP_ALLOC;
        end
    end

    assign take_en = (op == OP_ALLOC) && any_free;

    rid_fields #(
        .ID_LSB(ID_LSB), .ID_W(ID_W), .ERR_LSB(ERR_LSB), .ERR_W(ERR_W)
    ) u_fields (
        .word(ring_rd_data), .id(word_id), .err(word_err)
    );

    rid_pool #(
        .NUM_IDS(NUM_IDS), .CTX_W(CTX_W), .ID_W(ID_W)
    ) u_pool (
        .clk(clk), .rst(rst),
        .take_en(take_en), .take_ctx(alloc_ctx),
        .give_en(op == OP_REL), .give_id(rel_id),
        .cpl_en(walk_take), .cpl_id(word_id),
        .any_free(any_free), .low_id(low_id),
        .give_used(give_used), .cpl_used(cpl_used), .cpl_ctx(pool_ctx)
    );

    rid_walker #(
        .RING_DEPTH(RING_DEPTH), .PTR_W(PTR_W), .BUD_W(BUD_W), .CNT_W(CNT_W)
    ) u_walker (
        .clk(clk), .rst(rst),
        .start(op == OP_DEQ), .budget(deq_budget), .pending(pending),
        .hw_wr_ptr(hw_wr_ptr),
        .busy(busy), .take(walk_take), .rd_ptr(ring_rd_addr),
        .done(deq_done), .done_count(deq_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pending    <= '0;
            alloc_done <= 1'b0;
            alloc_fail <= 1'b0;
            alloc_id   <= '0;
            rel_done   <= 1'b0;
            cpl_valid  <= 1'b0;
            cpl_id     <= '0;
            cpl_ctx    <= '0;
            cpl_err    <= '0;
            cpl_hw_err <= 1'b0;
        end else begin
            alloc_done <= (op == OP_ALLOC);
            alloc_fail <= (op == OP_ALLOC) && !any_free;
            if (take_en) alloc_id <= low_id;
            rel_done   <= (op == OP_REL);
            cpl_valid  <= walk_take;
            if (walk_take) begin
                cpl_id     <= word_id;
                cpl_ctx    <= pool_ctx;
                cpl_err    <= word_err;
                cpl_hw_err <= (pool_ctx == '0);
            end
            if (take_en)
                pending <= pending + 1'b1;
            else if ((op == OP_REL && give_used) || (walk_take && cpl_used))
                pending <= pending - 1'b1;
        end
    end
endmodule

// File: rtl/rid_tracker_chk.sv
module rid_tracker_chk #(
    parameter int NUM_IDS    = 16,
    parameter int RING_DEPTH = 8,
    parameter int BUD_W      = 8,
    parameter int PTR_W      = 3,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_done,
    input logic             alloc_fail,
    input logic             deq_start,
    input logic [BUD_W-1:0] deq_budget,
    input logic             busy,
    input logic             cpl_valid,
    input logic             cpl_hw_err,
    input logic             deq_done,
    input logic [BUD_W-1:0] deq_count,
    input logic [CNT_W-1:0] pending,
    input logic [PTR_W-1:0] ring_rd_addr
);
    import rid_pkg::*;

    logic [BUD_W-1:0] lim_q;

    always_ff @(posedge clk) begin
        if (rst) lim_q <= '0;
        else if (deq_start && !busy)
            lim_q <= BUD_W'(umin(int'(deq_budget), int'(pending)));
    end

    assert_pending_bound_R1: assert property (@(posedge clk) disable iff (rst)
        int'(pending) <= NUM_IDS);

    assert_fail_when_full_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_fail |-> (int'(pending) == NUM_IDS));

    assert_cpl_step_R4: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> (pending == $past(pending) ||
                       ({1'b0, pending} + 1'b1) == {1'b0, $past(pending)}));

    assert_hw_err_keeps_count_R5: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && cpl_hw_err) |-> pending == $past(pending));

    assert_clamped_count_R6: assert property (@(posedge clk) disable iff (rst)
        deq_done |-> deq_count <= lim_q);

    assert_ptr_range_R8: assert property (@(posedge clk) disable iff (rst)
        int'(ring_rd_addr) < RING_DEPTH);

    assert_ptr_step_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(ring_rd_addr) |->
            ring_rd_addr == ((int'($past(ring_rd_addr)) == RING_DEPTH - 1) ?
                             '0 : $past(ring_rd_addr) + 1'b1));

    assert_no_alloc_in_run_R9: assert property (@(posedge clk) disable iff (rst)
        alloc_done |-> !busy);

    assert_cpl_only_in_run_R9: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> $past(busy));
endmodule

bind rid_tracker rid_tracker_chk #(
    .NUM_IDS(NUM_IDS), .RING_DEPTH(RING_DEPTH), .BUD_W(BUD_W),
    .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .alloc_done(alloc_done), .alloc_fail(alloc_fail),
    .deq_start(deq_start), .deq_budget(deq_budget), .busy(busy),
    .cpl_valid(cpl_valid), .cpl_hw_err(cpl_hw_err), .deq_done(deq_done),
    .deq_count(deq_count), .pending(pending), .ring_rd_addr(ring_rd_addr)
);

// File: tb/rid_tracker_bench.sv
module rid_tracker_bench;
    localparam int NUM_IDS = 16;
    localparam int CTX_W   = 16;
    localparam int DEPTH   = 8;
    localparam int BUD_W   = 8;
    localparam int ID_W    = 4;
    localparam int PTR_W   = 3;
    localparam int CNT_W   = 5;
    localparam int ERR_W   = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             alloc_req = 1'b0;
    logic [CTX_W-1:0] alloc_ctx = '0;
    logic             alloc_done, alloc_fail;
    logic [ID_W-1:0]  alloc_id;
    logic             rel_req = 1'b0;
    logic [ID_W-1:0]  rel_id = '0;
    logic             rel_done;
    logic             deq_start = 1'b0;
    logic [BUD_W-1:0] deq_budget = '0;
    logic [PTR_W-1:0] hw_wr_ptr = '0;
    logic [PTR_W-1:0] ring_rd_addr;
    logic [63:0]      ring_rd_data;
    logic             busy, cpl_valid, cpl_hw_err, deq_done;
    logic [ID_W-1:0]  cpl_id;
    logic [CTX_W-1:0] cpl_ctx;
    logic [ERR_W-1:0] cpl_err;
    logic [BUD_W-1:0] deq_count;
    logic [CNT_W-1:0] pending;

    logic [63:0] ring [DEPTH];
    assign ring_rd_data = ring[ring_rd_addr];

    always #2 clk = ~clk;

    rid_tracker u_rid_tracker (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_ctx(alloc_ctx), .alloc_done(alloc_done),
        .alloc_fail(alloc_fail), .alloc_id(alloc_id),
        .rel_req(rel_req), .rel_id(rel_id), .rel_done(rel_done),
        .deq_start(deq_start), .deq_budget(deq_budget), .hw_wr_ptr(hw_wr_ptr),
        .ring_rd_addr(ring_rd_addr), .ring_rd_data(ring_rd_data),
        .busy(busy), .cpl_valid(cpl_valid), .cpl_id(cpl_id), .cpl_ctx(cpl_ctx),
        .cpl_err(cpl_err), .cpl_hw_err(cpl_hw_err), .deq_done(deq_done),
        .deq_count(deq_count), .pending(pending)
    );

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        int id; int ctx; int err; int hw;
    } exp_t;
    exp_t sb[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    // scoreboard driver side
    task automatic expect_cpl(input int id, input int ctx, input int err, input int hw);
        exp_t e;
        e.id = id; e.ctx = ctx; e.err = err; e.hw = hw;
        sb.push_back(e);
    endtask

    // scoreboard monitor side
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cpl_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4 unexpected completion", int'(cpl_id), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check_eq("R4 cpl_id", int'(cpl_id), e.id);
                    check_eq("R4 cpl_ctx", int'(cpl_ctx), e.ctx);
                    check_eq("R4 cpl_err", int'(cpl_err), e.err);
                    check_eq("R5 cpl_hw_err", int'(cpl_hw_err), e.hw);
                end
            end
        end
    end

    function automatic logic [63:0] mkdesc(input int id, input int err);
        return 64'h2000_0000_1234_5670 | (64'(err) << 48) | 64'(id);
    endfunction

    task automatic do_alloc(input int ctx, input int exp_id, input bit exp_fail, input string tag);
        @(negedge clk);
        alloc_req = 1'b1;
        alloc_ctx = CTX_W'(ctx);
        do @(negedge clk); while (!alloc_done);
        alloc_req = 1'b0;
        check_eq({tag, " alloc_fail"}, int'(alloc_fail), int'(exp_fail));
        if (!exp_fail) check_eq({tag, " alloc_id"}, int'(alloc_id), exp_id);
    endtask

    task automatic do_release(input int id);
        @(negedge clk);
        rel_req = 1'b1;
        rel_id  = ID_W'(id);
        do @(negedge clk); while (!rel_done);
        rel_req = 1'b0;
    endtask

    task automatic do_deq(input int budget, input int exp_cnt, input string tag);
        @(negedge clk);
        deq_start  = 1'b1;
        deq_budget = BUD_W'(budget);
        @(negedge clk);
        deq_start = 1'b0;
        while (!deq_done) @(negedge clk);
        check_eq({tag, " deq_count"}, int'(deq_count), exp_cnt);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R10 pending", int'(pending), 0);
        check_eq("R10 rd_addr", int'(ring_rd_addr), 0);
        check_eq("R10 busy", int'(busy), 0);
        check_eq("R10 outputs", int'({alloc_done, rel_done, cpl_valid, deq_done}), 0);
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit seen_early;
        for (int i = 0; i < DEPTH; i++) ring[i] = '0;
        do_reset();

        // R1 lowest free id
        for (int i = 0; i < 4; i++) do_alloc('h101 + i, i, 1'b0, "R1 first");
        check_eq("R1 pending", int'(pending), 4);

        // R3 release in-use, then a free id
        do_release(1);
        check_eq("R3 pending after release", int'(pending), 3);
        do_release(9);
        check_eq("R3 free id release ignored", int'(pending), 3);
        do_alloc('h1AA, 1, 1'b0, "R1 reuse lowest");

        // R2 exhaustion
        for (int i = 0; i < 12; i++) do_alloc('h200 + i, 4 + i, 1'b0, "R1 fill");
        check_eq("R2 pending full", int'(pending), 16);
        do_alloc('h777, 0, 1'b1, "R2 exhausted");
        check_eq("R2 pending unchanged", int'(pending), 16);

        // R4/R6 budget limit, R7 stop at write pointer
        ring[0] = mkdesc(2, 3);
        ring[1] = mkdesc(1, 0);
        ring[2] = mkdesc(5, 'hA);
        hw_wr_ptr = 3'd3;
        expect_cpl(2, 'h103, 3, 0);
        expect_cpl(1, 'h1AA, 0, 0);
        do_deq(2, 2, "R6 budget");
        check_eq("R8 rd_addr", int'(ring_rd_addr), 2);
        check_eq("R4 pending", int'(pending), 14);
        expect_cpl(5, 'h201, 'hA, 0);
        do_deq(10, 1, "R7 stop at wr");
        check_eq("R7 rd_addr", int'(ring_rd_addr), 3);
        check_eq("R7 pending", int'(pending), 13);
        do_alloc('h5, 1, 1'b0, "R4 freed id reused");

        // R6 clamp to pending
        do_reset();
        hw_wr_ptr = 3'd0;
        do_alloc('h301, 0, 1'b0, "R1 after reset");
        do_alloc('h302, 1, 1'b0, "R1 after reset");
        ring[0] = mkdesc(1, 0);
        ring[1] = mkdesc(0, 1);
        ring[2] = mkdesc(7, 2);
        ring[3] = mkdesc(0, 0);
        hw_wr_ptr = 3'd4;
        expect_cpl(1, 'h302, 0, 0);
        expect_cpl(0, 'h301, 1, 0);
        do_deq(10, 2, "R6 clamp");
        check_eq("R6 rd_addr", int'(ring_rd_addr), 2);
        check_eq("R6 pending", int'(pending), 0);

        // R5 completion for an id with no context
        do_alloc('h303, 0, 1'b0, "R1 refill");
        expect_cpl(7, 0, 2, 1);
        do_deq(1, 1, "R5 hw err");
        check_eq("R5 pending kept", int'(pending), 1);
        expect_cpl(0, 'h303, 0, 0);
        do_deq(5, 1, "R6 clamp one");
        check_eq("R6 pending zero", int'(pending), 0);

        // R8 wrap with R9 allocation held during the run
        for (int i = 0; i < 5; i++) do_alloc('h400 + i, i, 1'b0, "R1 wrap fill");
        for (int i = 0; i < 4; i++) ring[4 + i] = mkdesc(i, i);
        ring[0] = mkdesc(4, 9);
        hw_wr_ptr = 3'd1;
        for (int i = 0; i < 5; i++) expect_cpl(i, 'h400 + i, (i == 4) ? 9 : i, 0);
        @(negedge clk);
        deq_start  = 1'b1;
        deq_budget = 8'd8;
        alloc_req  = 1'b1;
        alloc_ctx  = 16'h4FF;
        @(negedge clk);
        deq_start = 1'b0;
        seen_early = 1'b0;
        while (!deq_done) begin
            if (alloc_done) seen_early = 1'b1;
            @(negedge clk);
        end
        check_eq("R9 alloc held during run", int'(seen_early), 0);
        check_eq("R8 wrap count", int'(deq_count), 5);
        check_eq("R8 rd_addr wrapped", int'(ring_rd_addr), 1);
        while (!alloc_done) @(negedge clk);
        alloc_req = 1'b0;
        check_eq("R9 alloc after run id", int'(alloc_id), 0);
        check_eq("R9 pending", int'(pending), 1);

        repeat (3) @(negedge clk);
        check_eq("R4 scoreboard drained", sb.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule